// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block handles the hardware side of entering and leaving an interrupt service routine. When the interrupt logic accepts an interrupt, the sequencer snapshots the live processor state and writes it byte by byte onto a downward-growing stack in a single-port byte memory. It then hands the core the routine's start address from the vector input. When the routine signals its return, the sequencer reads the saved bytes back in reverse order. It presents the restored registers to the core and reloads the program counter from the stack.

A mode input chooses between two save styles. The full style stores the program counter, both 16-bit index registers, both accumulators and the condition-code byte. The fast style stores only the program counter and leaves the other registers to software. The full style costs nine memory cycles each way and the fast style costs two. A busy flag covers every stack access. Instruction decode, arithmetic and interrupt prioritisation are handled elsewhere.

Top module: `ctx_stacker`

## Requirements
- R1: After reset, sp_o is 8'hFF, busy_o, mem_we_o, mem_re_o, pc_load_o and ctx_valid_o are low, and the mode register holds full save.
- R2: When accept_i is high in an idle cycle with mode_full_i=1, the next nine cycles each write one byte at address sp_o, with sp_o decremented after each write. Slot order: 0 PC low, 1 PC high, 2 Y low, 3 Y high, 4 X low, 5 X high, 6 accumulator A, 7 accumulator B, 8 condition code.
- R3: With mode_full_i=0 when a sequence starts, only slots 0 and 1 are written, in two cycles. The mode input is sampled only in the idle cycle that starts a save or a restore.
- R4: The register inputs and vector_i are captured in the accept cycle, so later changes do not affect the stored bytes. In the cycle after the last write, pc_o equals the captured vector and pc_load_o is high for that one cycle.
- R5: busy_o is high exactly in the cycles that access the stack (nine for full, two for fast). mem_we_o and mem_re_o are never high together.
- R6: When a return starts in full mode, nine read cycles follow. Each read takes address sp_o+1 and then increments sp_o, and read data is used in the same cycle it is addressed. The slots are read in descending order 8 down to 0. In the cycle after the last read, pc_o, rest_iy_o, rest_ix_o, rest_acc_a_o, rest_acc_b_o and rest_ccr_o show the popped values, and pc_load_o and ctx_valid_o are high for one cycle.
- R7: A fast-mode return reads only slot 1 then slot 0 and updates pc_o. The other restored outputs keep their previous values.
- R8: A reti_i pulse during a save is held. The restore begins after the save ends, with its first read two cycles after the last write.
- R9: accept_i is acted on only in an idle cycle. Asserted during a restore, it has no effect and no save follows. When accept_i and reti_i coincide in an idle cycle, the save runs first and the return is held.
- R10: A second accept after a completed save stacks a new frame below the first. The returns then unwind the frames in last-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| accept_i | input | 1 | Interrupt accepted, acted on when idle |
| vector_i | input | 16 | Start address of the service routine |
| reti_i | input | 1 | Return-from-interrupt strobe |
| mode_full_i | input | 1 | 1 = full context save, 0 = PC only |
| pc_lo_i | input | 8 | Live PC low byte |
| pc_hi_i | input | 8 | Live PC high byte |
| iy_i | input | 16 | Live index register Y |
| ix_i | input | 16 | Live index register X |
| acc_a_i | input | 8 | Live accumulator A |
| acc_b_i | input | 8 | Live accumulator B |
| ccr_i | input | 8 | Live condition-code byte |
| mem_we_o | output | 1 | Stack memory write enable |
| mem_re_o | output | 1 | Stack memory read enable |
| mem_addr_o | output | 8 | Stack memory address |
| mem_wdata_o | output | 8 | Stack memory write data |
| mem_rdata_i | input | 8 | Stack memory read data, combinational |
| sp_o | output | 8 | Stack pointer |
| pc_o | output | 16 | New program counter |
| pc_load_o | output | 1 | One-cycle strobe: load pc_o |
| busy_o | output | 1 | Stack sequence in progress |
| ctx_valid_o | output | 1 | One-cycle strobe: restored registers valid |
| rest_iy_o | output | 16 | Restored index register Y |
| rest_ix_o | output | 16 | Restored index register X |
| rest_acc_a_o | output | 8 | Restored accumulator A |
| rest_acc_b_o | output | 8 | Restored accumulator B |
| rest_ccr_o | output | 8 | Restored condition-code byte |

## Verification
Several properties are checked on every cycle: the stack pointer moves by exactly one after each write and each read, and a read never coincides with a write. A PC load only follows a busy sequence, a return seen during a save is always latched, and a save never follows directly after a restore. The actual byte order, the reverse read order, the LIFO unwinding of nested frames, the capture of inputs at accept time and the fast-mode outputs that must stay unchanged can only be shown by the bench's scenarios. Those scenarios model the stack memory and compare every address, data byte and restored value against expectations.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  localparam int NB_FULL = 9;
  localparam int NB_FAST = 2;
  localparam int CNT_W   = 4;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} seq_e;

  // byte k of the packed frame lives at [8k+7:8k]; k is the push slot
  typedef struct packed {
    logic [7:0]  ccr;
    logic [7:0]  acc_b;
    logic [7:0]  acc_a;
    logic [15:0] ix;
    logic [15:0] iy;
    logic [7:0]  pc_hi;
    logic [7:0]  pc_lo;
  } ctx_t;

  function automatic logic [7:0] ctx_slot(ctx_t c, logic [CNT_W-1:0] s);
    case (s)
      4'd0:    return c.pc_lo;
      4'd1:    return c.pc_hi;
      4'd2:    return c.iy[7:0];
      4'd3:    return c.iy[15:8];
      4'd4:    return c.ix[7:0];
      4'd5:    return c.ix[15:8];
      4'd6:    return c.acc_a;
      4'd7:    return c.acc_b;
      default: return c.ccr;
    endcase
  endfunction
endpackage

// File: rtl/ctx_fsm.sv
module ctx_fsm
  import ctx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             reti_i,
  input  logic             mode_full_i,
  output seq_e             state_o,
  output logic [CNT_W-1:0] slot_o,
  output logic             last_o,
  output logic             start_push_o
);
  seq_e             state_q;
  logic [CNT_W-1:0] cnt_q, n_bytes;
  logic             mode_q, ret_pend_q;

  assign n_bytes      = mode_q ? CNT_W'(NB_FULL) : CNT_W'(NB_FAST);
  assign last_o       = (cnt_q == n_bytes - CNT_W'(1));
  assign slot_o       = (state_q == S_PUSH) ? cnt_q : (n_bytes - CNT_W'(1) - cnt_q);
  assign state_o      = state_q;
  assign start_push_o = (state_q == S_IDLE) && accept_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      mode_q     <= 1'b1;
      ret_pend_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          cnt_q <= '0;
          if (accept_i) begin
            state_q    <= S_PUSH;
            mode_q     <= mode_full_i;
            ret_pend_q <= ret_pend_q | reti_i;
          end else if (reti_i || ret_pend_q) begin
            state_q    <= S_POP;
            mode_q     <= mode_full_i;
            ret_pend_q <= 1'b0;
          end
        end
        S_PUSH: begin
          ret_pend_q <= ret_pend_q | reti_i;  // return waits for save end
          if (last_o) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        S_POP: begin
          if (last_o) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R8: return seen during a save is latched
  a_r8_ret_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PUSH && reti_i) |=> ret_pend_q);
  // R9: a restore is never followed directly by a save
  a_r9_no_push_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POP) |=> (state_q != S_PUSH));
  // R5: counter stays inside the frame
  a_r5_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < n_bytes);
endmodule

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] SP_RST = {AW{1'b1}};
  logic [AW-1:0] sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= SP_RST;
    else if (push_i) sp_q <= sp_q - AW'(1);  // post-decrement
    else if (pop_i)  sp_q <= sp_q + AW'(1);  // pre-increment
  end

  assign sp_o   = sp_q;
  assign addr_o = pop_i ? sp_q + AW'(1) : sp_q;
endmodule

// File: rtl/ctx_restore.sv
module ctx_restore
  import ctx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] slot_i,
  input  logic [7:0]       din_i,
  output ctx_t             ctx_o
);
  logic [8*NB_FULL-1:0] flat;

  for (genvar k = 0; k < NB_FULL; k++) begin : g_slot
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q <= '0;
      else if (wr_i && slot_i == CNT_W'(k)) byte_q <= din_i;
    end
    assign flat[8*k +: 8] = byte_q;
  end

  assign ctx_o = ctx_t'(flat);
endmodule

// File: rtl/ctx_stacker.sv
module ctx_stacker
  import ctx_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [15:0]   vector_i,
  input  logic          reti_i,
  input  logic          mode_full_i,
  input  logic [7:0]    pc_lo_i,
  input  logic [7:0]    pc_hi_i,
  input  logic [15:0]   iy_i,
  input  logic [15:0]   ix_i,
  input  logic [7:0]    acc_a_i,
  input  logic [7:0]    acc_b_i,
  input  logic [7:0]    ccr_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic [AW-1:0] sp_o,
  output logic [15:0]   pc_o,
  output logic          pc_load_o,
  output logic          busy_o,
  output logic          ctx_valid_o,
  output logic [15:0]   rest_iy_o,
  output logic [15:0]   rest_ix_o,
  output logic [7:0]    rest_acc_a_o,
  output logic [7:0]    rest_acc_b_o,
  output logic [7:0]    rest_ccr_o
);
  seq_e             state;
  logic [CNT_W-1:0] slot;
  logic             last, start_push, push, pop;
  ctx_t             snap_q, rest;
  logic [15:0]      vec_q;
  logic             pc_sel_q, pc_load_q, valid_q;

  ctx_fsm u_fsm (
    .clk_i, .rst_ni, .accept_i, .reti_i, .mode_full_i,
    .state_o(state), .slot_o(slot), .last_o(last), .start_push_o(start_push)
  );

  assign push = (state == S_PUSH);
  assign pop  = (state == S_POP);

  ctx_sp_unit #(.AW(AW)) u_sp (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .sp_o, .addr_o(mem_addr_o)
  );

  ctx_restore u_rest (
    .clk_i, .rst_ni, .wr_i(pop), .slot_i(slot), .din_i(mem_rdata_i), .ctx_o(rest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q    <= '0;
      vec_q     <= '0;
      pc_sel_q  <= 1'b0;
      pc_load_q <= 1'b0;
      valid_q   <= 1'b0;
    end else begin
      if (start_push) begin
        snap_q <= '{ccr: ccr_i, acc_b: acc_b_i, acc_a: acc_a_i, ix: ix_i,
                    iy: iy_i, pc_hi: pc_hi_i, pc_lo: pc_lo_i};
        vec_q  <= vector_i;
      end
      pc_load_q <= last && (push || pop);
      valid_q   <= last && pop;
      if (last && push) pc_sel_q <= 1'b0;
      else if (last && pop) pc_sel_q <= 1'b1;
    end
  end

  assign mem_we_o     = push;
  assign mem_re_o     = pop;
  assign mem_wdata_o  = ctx_slot(snap_q, slot);
  assign busy_o       = push || pop;
  assign pc_o         = pc_sel_q ? {rest.pc_hi, rest.pc_lo} : vec_q;
  assign pc_load_o    = pc_load_q;
  assign ctx_valid_o  = valid_q;
  assign rest_iy_o    = rest.iy;
  assign rest_ix_o    = rest.ix;
  assign rest_acc_a_o = rest.acc_a;
  assign rest_acc_b_o = rest.acc_b;
  assign rest_ccr_o   = rest.ccr;

  // R2: pointer moves down one per write
  a_r2_push_sp_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == $past(sp_o) - AW'(1));
  // R6: pointer moves up one per read
  a_r6_pop_sp_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> sp_o == $past(sp_o) + AW'(1));
  // R5: single-port memory, never read and write together
  a_r5_port_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  // R4: PC load strobe only right after a stack sequence
  a_r4_load_after_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> $past(busy_o));
endmodule

// File: tb/tb_ctx_stacker.sv
`timescale 1ns/1ps
module tb_ctx_stacker;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        accept_i = 1'b0, reti_i = 1'b0, mode_full_i = 1'b1;
  logic [15:0] vector_i = '0, iy_i = '0, ix_i = '0;
  logic [7:0]  pc_lo_i = '0, pc_hi_i = '0, acc_a_i = '0, acc_b_i = '0, ccr_i = '0;
  logic        mem_we, mem_re, pc_load, busy, ctx_valid;
  logic [7:0]  mem_addr, mem_wdata, mem_rdata, sp, rest_a, rest_b, rest_ccr;
  logic [15:0] pc, rest_iy, rest_ix;
  logic [7:0]  mem [0:255];

  int total = 0, bad = 0;
  int esp = 255;
  logic [71:0] prev_rest = '0;

  always #2.5 clk = ~clk;

  ctx_stacker dut (
    .clk_i(clk), .rst_ni, .accept_i, .vector_i, .reti_i, .mode_full_i,
    .pc_lo_i, .pc_hi_i, .iy_i, .ix_i, .acc_a_i, .acc_b_i, .ccr_i,
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .sp_o(sp), .pc_o(pc),
    .pc_load_o(pc_load), .busy_o(busy), .ctx_valid_o(ctx_valid),
    .rest_iy_o(rest_iy), .rest_ix_o(rest_ix), .rest_acc_a_o(rest_a),
    .rest_acc_b_o(rest_b), .rest_ccr_o(rest_ccr)
  );

  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
  assign mem_rdata = mem[mem_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // frame layout {ccr,b,a,ix,iy,pc_hi,pc_lo}; byte k = push slot k
  task automatic drive_regs(input logic [71:0] c);
    {ccr_i, acc_b_i, acc_a_i, ix_i, iy_i, pc_hi_i, pc_lo_i} = c;
  endtask

  task automatic t_save(input bit full, input logic [15:0] vec, input logic [71:0] c,
                        input int reti_at, input bit with_ret);
    int n = full ? 9 : 2;
    @(negedge clk);
    mode_full_i = full; accept_i = 1'b1; reti_i = with_ret; vector_i = vec; drive_regs(c);
    @(negedge clk);
    accept_i = 1'b0; vector_i = ~vec; drive_regs(~c);  // R4 capture check
    for (int k = 0; k < n; k++) begin
      reti_i = (k == reti_at);
      chk("R5 busy in push", busy, 1);
      chk("R2 write strobe", mem_we, 1);
      chk("R2 write addr", mem_addr, esp[7:0]);
      chk("R2 R4 write byte", mem_wdata, c[8*k +: 8]);
      @(negedge clk);
      esp = (esp - 1) & 255;
    end
    reti_i = 1'b0;
    chk("R5 busy low after push", busy, 0);
    chk("R4 pc load strobe", pc_load, 1);
    chk("R4 pc vector", pc, vec);
    chk("R2 sp after push", sp, esp[7:0]);
  endtask

  task automatic t_pop(input bit full, input logic [71:0] c, input int acc_at);
    int n = full ? 9 : 2;
    for (int j = 0; j < n; j++) begin
      accept_i = (j == acc_at);
      chk("R5 busy in pop", busy, 1);
      chk("R6 read strobe", mem_re, 1);
      chk("R5 no write in pop", mem_we, 0);
      chk("R6 read addr", mem_addr, (esp + 1) & 255);
      @(negedge clk);
      esp = (esp + 1) & 255;
    end
    accept_i = 1'b0;
    chk("R6 pc load", pc_load, 1);
    chk("R6 ctx valid", ctx_valid, 1);
    chk("R6 restored pc", pc, c[15:0]);
    chk("R6 sp after pop", sp, esp[7:0]);
    if (full) begin
      chk("R6 rest iy", rest_iy, c[31:16]);
      chk("R6 rest ix", rest_ix, c[47:32]);
      chk("R6 rest a", rest_a, c[55:48]);
      chk("R6 rest b", rest_b, c[63:56]);
      chk("R6 rest ccr", rest_ccr, c[71:64]);
      prev_rest = c;
    end else begin
      chk("R7 rest iy kept", rest_iy, prev_rest[31:16]);
      chk("R7 rest ccr kept", rest_ccr, prev_rest[71:64]);
      chk("R7 rest a/b kept", {rest_a, rest_b, rest_ix}, {prev_rest[55:48], prev_rest[63:56], prev_rest[47:32]});
    end
  endtask

  task automatic t_ret(input bit full, input logic [71:0] c, input int acc_at);
    @(negedge clk);
    mode_full_i = full; reti_i = 1'b1;
    @(negedge clk);
    reti_i = 1'b0;
    t_pop(full, c, acc_at);
  endtask

  localparam logic [71:0] CA = 72'hC1_B2_A3_4455_6677_1F_2E;
  localparam logic [71:0] CB = 72'h99_88_77_6655_4433_3C_4D;
  localparam logic [71:0] CC = 72'h0F_1E_2D_3C4B_5A69_78_87;
  localparam logic [71:0] CD = 72'hF0_E1_D2_C3B4_A596_87_78;
  localparam logic [71:0] CE = 72'h11_22_33_4455_6677_88_99;

  task automatic sc_reset;
    chk("R1 sp reset", sp, 8'hFF);
    chk("R1 busy reset", busy, 0);
    chk("R1 strobes reset", {mem_we, mem_re, pc_load, ctx_valid}, 0);
  endtask

  task automatic sc_full_roundtrip;
    t_save(1, 16'h4000, CA, -1, 0);
    @(negedge clk);
    chk("R4 pc load one cycle", pc_load, 0);
    t_ret(1, CA, -1);
  endtask

  task automatic sc_fast_roundtrip;
    t_save(0, 16'h5000, CB, -1, 0);
    chk("R3 fast frame size", sp, 8'hFD);
    @(negedge clk);
    chk("R3 no further writes", mem_we, 0);
    t_ret(0, CB, -1);
  endtask

  task automatic sc_nested;
    t_save(1, 16'h8000, CA, -1, 0);
    t_save(0, 16'h9000, CB, -1, 0);
    chk("R10 inner frame below outer", sp, 8'hF4);
    t_ret(0, CB, -1);
    t_ret(1, CA, -1);
    chk("R10 stack unwound", sp, 8'hFF);
  endtask

  task automatic sc_ret_during_push;
    t_save(1, 16'hA000, CC, 3, 0);
    chk("R8 no read at save end", mem_re, 0);
    @(negedge clk);
    chk("R8 pop starts after save", mem_re, 1);
    t_pop(1, CC, -1);
  endtask

  task automatic sc_accept_in_pop;
    t_save(1, 16'hB000, CD, -1, 0);
    t_ret(1, CD, 2);
    @(negedge clk);
    chk("R9 accept in pop ignored busy", busy, 0);
    @(negedge clk);
    chk("R9 accept in pop ignored sp", sp, 8'hFF);
  endtask

  task automatic sc_both_strobes;
    t_save(1, 16'hC000, CA, -1, 0);
    t_save(1, 16'hD000, CE, -1, 1);
    @(negedge clk);
    chk("R9 held return starts", mem_re, 1);
    t_pop(1, CE, -1);
    t_ret(1, CA, -1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    sc_reset();
    sc_full_roundtrip();
    sc_fast_roundtrip();
    sc_nested();
    sc_ret_during_push();
    sc_accept_in_pop();
    sc_both_strobes();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule